// File: doc/BRIEF.md
# Dual-Use Pad Ownership Arbiter

This block decides who drives each pad in a bank of pins that serve both the user design and the configuration engine. For every pin, the configuration engine can raise a claim flag. A claimed pin takes its output value and output enable from the configuration side. An unclaimed pin takes them from user logic. The value read back from each pad always goes to both sides, whichever of them owns the pin.

One pin of the bank, chosen by parameter, can act as a global output-tristate input. A control bit switches this function on. While the bit is set and that pad sits at its active level, every unclaimed user output in the bank is tristated in the same cycle, with no register in the path. Claimed pins keep their configuration drive. The first time the control bit is seen set, the override pin becomes a permanent input, and only reset returns it to user I/O. The per-pin pad settings (pull resistors, input threshold, hysteresis) come from user logic alone. Configuration ownership never touches them.

Top module: `dup_arbiter`

## Requirements
- R1: With the override control bit low, a pin whose claim flag is low drives `pad_o`/`pad_oe_o` equal to its `usr_o_i`/`usr_oe_i` bits.
- R2: A pin whose claim flag is high drives `pad_o`/`pad_oe_o` equal to its `cfg_o_i`/`cfg_oe_i` bits. The override pin is the exception once it is locked as an input (R5).
- R3: While `ovr_en_i` is high and `pad_i[OVR_PIN]` equals `OVR_LEVEL`, every unclaimed pin other than the override pin has `pad_oe_o` low in the same cycle. Its `pad_o` still follows `usr_o_i`.
- R4: While `ovr_en_i` is low, the level of `pad_i[OVR_PIN]` has no effect on any output enable.
- R5: While `ovr_en_i` is high, and in every cycle after a rising clock edge at which it was high (until reset), the override pin has `pad_oe_o` = 0 and `pad_o` = 0, whatever its claim, user or configuration inputs.
- R6: During an active override (R3), claimed pins keep driving `cfg_o_i`/`cfg_oe_i`.
- R7: `usr_in_o` and `cfg_in_o` both equal `pad_i` on every pin at all times, claimed or not.
- R8: `pad_set_o` equals `usr_set_i` at all times, independent of claims and of the override. Pin i uses bits [i*SET_W +: SET_W].
- R9: Asserting `rst_n` low unlocks the override pin, so with `ovr_en_i` low it behaves as ordinary user I/O again (R1).
- R10: The override's active level is the parameter `OVR_LEVEL`, default 0. A pad level of 1 with `ovr_en_i` high leaves unclaimed user pins on their own enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the override lock state |
| rst_n | input | 1 | Asynchronous active-low reset, clears the lock |
| ovr_en_i | input | 1 | Control bit that enables the override function |
| usr_o_i | input | NUM_PINS | User output values |
| usr_oe_i | input | NUM_PINS | User output enables |
| cfg_o_i | input | NUM_PINS | Configuration output values |
| cfg_oe_i | input | NUM_PINS | Configuration output enables |
| cfg_claim_i | input | NUM_PINS | Per-pin configuration claim flags |
| usr_set_i | input | NUM_PINS*SET_W | User pad settings, SET_W bits per pin |
| pad_i | input | NUM_PINS | Values read from the pads |
| pad_o | output | NUM_PINS | Final pad output values |
| pad_oe_o | output | NUM_PINS | Final pad output enables |
| pad_set_o | output | NUM_PINS*SET_W | Pad settings forwarded to the pads |
| usr_in_o | output | NUM_PINS | Pad inputs forwarded to user logic |
| cfg_in_o | output | NUM_PINS | Pad inputs forwarded to configuration logic |

## Verification
The only internal state is the override lock. If it is set when it should not be, the override pin's enable drops although `ovr_en_i` was never high. If it fails to set, or clears too early, the override pin drives again in the first cycle after `ovr_en_i` falls. Both show on `pad_oe_o[OVR_PIN]` within one clock. Every other path is combinational, so a wrong priority between claim, override and user drive shows on `pad_oe_o` in the same cycle as the input pattern that triggers it. The bench follows the lock across long random runs in which `ovr_en_i` toggles, and again after a reset pulse.

// File: rtl/dup_pkg.sv
package dup_pkg;

   // Which source supplies a pad's output value and enable
   typedef enum logic [1:0] {
      SRC_USER   = 2'd0,
      SRC_CFG    = 2'd1,
      SRC_USR_HZ = 2'd2,
      SRC_PARKED = 2'd3
   } drv_src_e;

   typedef struct packed {
      logic o;
      logic oe;
   } pad_drv_t;

   // Ownership order: locked override pin, then claim, then global tristate, then user
   function automatic drv_src_e pick_src(input logic locked,
                                         input logic claim,
                                         input logic tri_all);
      if (locked)       return SRC_PARKED;
      else if (claim)   return SRC_CFG;
      else if (tri_all) return SRC_USR_HZ;
      else              return SRC_USER;
   endfunction

endpackage

// File: rtl/dup_ovr_ctrl.sv
module dup_ovr_ctrl #(
   parameter bit OVR_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ovr_en_i,
   input  logic sense_i,
   output logic tri_all_o,
   output logic locked_o
);

   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        armed_q <= 1'b0;
      else if (ovr_en_i) armed_q <= 1'b1;
   end

   // The pin becomes an input in the same cycle the function is enabled
   assign locked_o  = armed_q | ovr_en_i;
   assign tri_all_o = ovr_en_i & (sense_i == OVR_LEVEL);

endmodule

// File: rtl/dup_pin_mux.sv
module dup_pin_mux
   import dup_pkg::*;
(
   input  logic usr_o_i,
   input  logic usr_oe_i,
   input  logic cfg_o_i,
   input  logic cfg_oe_i,
   input  logic claim_i,
   input  logic tri_all_i,
   input  logic locked_i,
   output logic pad_o,
   output logic pad_oe_o
);

   drv_src_e src;
   pad_drv_t drv;

   always_comb begin
      src = pick_src(locked_i, claim_i, tri_all_i);
      unique case (src)
         SRC_CFG:    drv = '{o: cfg_o_i, oe: cfg_oe_i};
         SRC_USR_HZ: drv = '{o: usr_o_i, oe: 1'b0};
         SRC_PARKED: drv = '{o: 1'b0,    oe: 1'b0};
         default:    drv = '{o: usr_o_i, oe: usr_oe_i};
      endcase
   end

   assign pad_o    = drv.o;
   assign pad_oe_o = drv.oe;

endmodule

// File: rtl/dup_arbiter.sv
module dup_arbiter #(
   parameter int NUM_PINS  = 8,
   parameter int SET_W     = 3,
   parameter bit HAS_OVR   = 1'b1,
   parameter int OVR_PIN   = NUM_PINS - 1,
   parameter bit OVR_LEVEL = 1'b0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ovr_en_i,
   input  logic [NUM_PINS-1:0]       usr_o_i,
   input  logic [NUM_PINS-1:0]       usr_oe_i,
   input  logic [NUM_PINS-1:0]       cfg_o_i,
   input  logic [NUM_PINS-1:0]       cfg_oe_i,
   input  logic [NUM_PINS-1:0]       cfg_claim_i,
   input  logic [NUM_PINS*SET_W-1:0] usr_set_i,
   input  logic [NUM_PINS-1:0]       pad_i,
   output logic [NUM_PINS-1:0]       pad_o,
   output logic [NUM_PINS-1:0]       pad_oe_o,
   output logic [NUM_PINS*SET_W-1:0] pad_set_o,
   output logic [NUM_PINS-1:0]       usr_in_o,
   output logic [NUM_PINS-1:0]       cfg_in_o
);

   localparam int SET_TOTAL = NUM_PINS * SET_W;

   // Elaboration-time parameter checks
   if (NUM_PINS < 2) begin : g_bad_pins
      $error("dup_arbiter: NUM_PINS must be at least 2");
   end
   if (SET_W < 1) begin : g_bad_set
      $error("dup_arbiter: SET_W must be at least 1");
   end
   if (OVR_PIN < 0 || OVR_PIN >= NUM_PINS) begin : g_bad_ovr
      $error("dup_arbiter: OVR_PIN out of range");
   end

   logic                tri_all;
   logic                ovr_locked;
   logic [NUM_PINS-1:0] locked_vec;

   if (HAS_OVR) begin : g_ovr
      dup_ovr_ctrl #(
         .OVR_LEVEL (OVR_LEVEL)
      ) u_ovr (
         .clk       (clk),
         .rst_n     (rst_n),
         .ovr_en_i  (ovr_en_i),
         .sense_i   (pad_i[OVR_PIN]),
         .tri_all_o (tri_all),
         .locked_o  (ovr_locked)
      );
   end else begin : g_no_ovr
      logic unused_ovr;
      assign unused_ovr = &{1'b0, clk, rst_n, ovr_en_i};
      assign tri_all    = 1'b0;
      assign ovr_locked = 1'b0;
   end

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      if (i == OVR_PIN) begin : g_lock
         assign locked_vec[i] = ovr_locked;
      end else begin : g_free
         assign locked_vec[i] = 1'b0;
      end

      dup_pin_mux u_mux (
         .usr_o_i   (usr_o_i[i]),
         .usr_oe_i  (usr_oe_i[i]),
         .cfg_o_i   (cfg_o_i[i]),
         .cfg_oe_i  (cfg_oe_i[i]),
         .claim_i   (cfg_claim_i[i]),
         .tri_all_i (tri_all),
         .locked_i  (locked_vec[i]),
         .pad_o     (pad_o[i]),
         .pad_oe_o  (pad_oe_o[i])
      );

      // Pad settings stay with user logic on every pin
      assign pad_set_o[i*SET_W +: SET_W] = usr_set_i[i*SET_W +: SET_W];
   end

   // Input buffers stay live for both consumers
   assign usr_in_o = pad_i;
   assign cfg_in_o = pad_i;

   logic unused_w;
   assign unused_w = (SET_TOTAL == 0);

endmodule

// File: rtl/dup_arbiter_chk.sv
module dup_arbiter_chk #(
   parameter int NUM_PINS  = 8,
   parameter int SET_W     = 3,
   parameter bit HAS_OVR   = 1'b1,
   parameter int OVR_PIN   = NUM_PINS - 1,
   parameter bit OVR_LEVEL = 1'b0
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      ovr_en_i,
   input logic [NUM_PINS-1:0]       usr_o_i,
   input logic [NUM_PINS-1:0]       cfg_o_i,
   input logic [NUM_PINS-1:0]       cfg_oe_i,
   input logic [NUM_PINS-1:0]       cfg_claim_i,
   input logic [NUM_PINS*SET_W-1:0] usr_set_i,
   input logic [NUM_PINS-1:0]       pad_i,
   input logic [NUM_PINS-1:0]       pad_o,
   input logic [NUM_PINS-1:0]       pad_oe_o,
   input logic [NUM_PINS*SET_W-1:0] pad_set_o,
   input logic [NUM_PINS-1:0]       usr_in_o,
   input logic [NUM_PINS-1:0]       cfg_in_o
);

   localparam logic [NUM_PINS-1:0] OVR_MASK =
      HAS_OVR ? ({{(NUM_PINS-1){1'b0}}, 1'b1} << OVR_PIN) : '0;
   localparam logic [NUM_PINS-1:0] FREE_MASK = ~OVR_MASK;

   // R3
   tri_all_users_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_OVR && ovr_en_i && (pad_i[OVR_PIN] == OVR_LEVEL))
      |-> ((pad_oe_o & ~cfg_claim_i & FREE_MASK) == '0)
          && (((pad_o ^ usr_o_i) & ~cfg_claim_i & FREE_MASK) == '0));

   // R6
   claim_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe_o & cfg_claim_i & FREE_MASK) == (cfg_oe_i & cfg_claim_i & FREE_MASK))
      && ((pad_o & cfg_claim_i & FREE_MASK) == (cfg_o_i & cfg_claim_i & FREE_MASK)));

   // R7
   inputs_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (usr_in_o == pad_i) && (cfg_in_o == pad_i));

   // R8
   settings_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pad_set_o == usr_set_i);

   // R5
   ovr_pin_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_OVR && ovr_en_i) |=> (!pad_oe_o[OVR_PIN] && !pad_o[OVR_PIN]));

   // R5
   ovr_pin_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_OVR && ovr_en_i) |-> !pad_oe_o[OVR_PIN]);

endmodule

bind dup_arbiter dup_arbiter_chk #(
   .NUM_PINS  (NUM_PINS),
   .SET_W     (SET_W),
   .HAS_OVR   (HAS_OVR),
   .OVR_PIN   (OVR_PIN),
   .OVR_LEVEL (OVR_LEVEL)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ovr_en_i    (ovr_en_i),
   .usr_o_i     (usr_o_i),
   .cfg_o_i     (cfg_o_i),
   .cfg_oe_i    (cfg_oe_i),
   .cfg_claim_i (cfg_claim_i),
   .usr_set_i   (usr_set_i),
   .pad_i       (pad_i),
   .pad_o       (pad_o),
   .pad_oe_o    (pad_oe_o),
   .pad_set_o   (pad_set_o),
   .usr_in_o    (usr_in_o),
   .cfg_in_o    (cfg_in_o)
);

// File: tb/dup_arbiter_test.sv
`timescale 1ns/1ps
module dup_arbiter_test;

   localparam int N   = 8;
   localparam int SW  = 3;
   localparam int OVR = N - 1;
   localparam bit LVL = 1'b0;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ovr_en;
   logic [N-1:0]  uo, uoe, co, coe, claim, pad;
   logic [N*SW-1:0] uset;
   logic [N-1:0]  po, poe, uin, cin;
   logic [N*SW-1:0] pset;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  armed_m = 1'b0;
   bit  done    = 1'b0;

   always #4 clk = ~clk;

   dup_arbiter #(.NUM_PINS(N), .SET_W(SW), .HAS_OVR(1'b1), .OVR_PIN(OVR), .OVR_LEVEL(LVL)) uut (
      .clk(clk), .rst_n(rst_n), .ovr_en_i(ovr_en),
      .usr_o_i(uo), .usr_oe_i(uoe), .cfg_o_i(co), .cfg_oe_i(coe),
      .cfg_claim_i(claim), .usr_set_i(uset), .pad_i(pad),
      .pad_o(po), .pad_oe_o(poe), .pad_set_o(pset),
      .usr_in_o(uin), .cfg_in_o(cin)
   );

   // Expected drive per requirement R1..R6, R10
   function automatic void model(input bit en, input bit armed,
                                 output logic [N-1:0] eo, output logic [N-1:0] eoe);
      bit tri_on;
      tri_on = en && (pad[OVR] == LVL);
      for (int i = 0; i < N; i++) begin
         if (i == OVR && (armed || en)) begin
            eo[i] = 1'b0; eoe[i] = 1'b0;
         end else if (claim[i]) begin
            eo[i] = co[i]; eoe[i] = coe[i];
         end else if (tri_on && i != OVR) begin
            eo[i] = uo[i]; eoe[i] = 1'b0;
         end else begin
            eo[i] = uo[i]; eoe[i] = uoe[i];
         end
      end
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Drive at negedge, check before the next rising edge, then follow the lock
   task automatic apply(input string tag);
      logic [N-1:0] eo, eoe;
      @(negedge clk);
      #1;
      model(ovr_en, armed_m, eo, eoe);
      chk(tag, "pad_o", 32'(po), 32'(eo));
      chk(tag, "pad_oe_o", 32'(poe), 32'(eoe));
      chk("R7", "usr_in_o", 32'(uin), 32'(pad));
      chk("R7", "cfg_in_o", 32'(cin), 32'(pad));
      chk("R8", "pad_set_o", 32'(pset), 32'(uset));
      @(posedge clk);
      if (rst_n && ovr_en) armed_m = 1'b1;
   endtask

   task automatic randomize_pins(input int claim_pct);
      uo   = N'($urandom);
      uoe  = N'($urandom);
      co   = N'($urandom);
      coe  = N'($urandom);
      pad  = N'($urandom);
      uset = (N*SW)'($urandom);
      for (int i = 0; i < N; i++) claim[i] = (($urandom % 100) < claim_pct);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      ovr_en = 1'b0; uo = '0; uoe = '1; co = '0; coe = '0; claim = '0;
      pad = '0; uset = '0;

      // R9: reset state, lock clear, override pin acts as user I/O
      apply("R9");
      @(negedge clk);
      rst_n = 1'b1;

      // R1 R2 R4: random traffic with override disabled, pad level random
      for (int k = 0; k < 300; k++) begin
         randomize_pins(40);
         apply("R1_R2_R4");
      end

      // R4: override level present but control bit low, all user enables kept
      claim = '0; uoe = '1; pad = '0; pad[OVR] = LVL; ovr_en = 1'b0;
      apply("R4");

      // R10: control bit high but pad at inactive level, no tristate
      claim = 8'h05; uoe = '1; coe = 8'h01; pad = '1; pad[OVR] = ~LVL; ovr_en = 1'b1;
      apply("R10");

      // R3 R6: active override, claimed pins keep configuration drive
      pad[OVR] = LVL; uo = 8'h5A; co = 8'hFF; coe = 8'h04;
      apply("R3_R6");

      // R5: override pin claimed and enabled by both sides, still an input
      claim[OVR] = 1'b1; coe[OVR] = 1'b1; uoe[OVR] = 1'b1; co[OVR] = 1'b1;
      apply("R5");

      // R5: control bit dropped, pin stays locked as input
      ovr_en = 1'b0; claim = '0; uoe = '1; uo = '1;
      apply("R5");
      apply("R5");

      // R3 R5 R6 R10: random traffic with the control bit toggling
      for (int k = 0; k < 400; k++) begin
         randomize_pins(30);
         ovr_en = (($urandom % 4) == 0);
         apply("R3_R5_R6");
      end

      // R9: reset pulse unlocks the override pin
      @(negedge clk);
      rst_n = 1'b0;
      armed_m = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      ovr_en = 1'b0; claim = '0; uoe = '1; uo = 8'hA5; pad = '0;
      apply("R9");

      // R1: more random traffic after reset, control bit low
      for (int k = 0; k < 100; k++) begin
         randomize_pins(0);
         apply("R1");
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule